// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block is the control state machine that takes a source-synchronous packet link from reset to an operational state. It walks the link through six ordered phases: self-test and reset, calendar programming, clock detection, training, calendar synchronisation and link-up. Each phase is handed to an external phase handler with a one-cycle go pulse on a one-hot vector. The handler replies with a shared completion strobe and an error flag that is sampled alongside it. The internals of each phase belong to the handler; this block only orders the phases, times them and reports the outcome.

A start command runs all six phases. A restart command is used after the link has lost synchronisation: it runs the same order but leaves out calendar programming, because the calendar contents survive. Three phases are timed: clock detection, training and calendar synchronisation. Their timeout counts prescaled ticks. It is reloaded on entry to each timed phase from the caller's value, except for training, which always uses a fixed and much longer limit. A phase error or a timeout ends the sequence at once. The phase that failed is then reported on a 3-bit code.

The 2-bit mode is captured when a command is accepted and is presented to the handlers for the whole run. Bit 0 enables the transmit half and bit 1 enables the receive half, so both bits set means duplex.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, busy_o, done_o and error_o are 0, fail_code_o is 7 (no failure) and phase_go_o is all zero.
- R2: A start command issues go pulses in this order: bit 0 (reset/self-test), bit 1 (calendar programming), bit 2 (clock detect), bit 3 (training), bit 4 (calendar sync), bit 5 (link-up). At most one bit of phase_go_o is high in any cycle, and each pulse lasts one cycle. When bit 5 completes without error, done_o rises and busy_o falls.
- R3: A restart command issues the same order as R2 but without bit 1 (calendar programming).
- R4: If phase_done_i arrives with phase_err_i high, error_o rises at the next edge and busy_o falls. fail_code_o then holds the failed phase's bit index, and no further go pulse is issued.
- R5: In clock detect (code 2) and calendar sync (code 4), if no completion arrives, error_o becomes visible exactly timeout*TICK_DIV+2 cycles after the cycle in which the go pulse is seen, with fail_code_o set to that phase. The timeout is the value of timeout_i captured at the command.
- R6: Training (code 3) ignores timeout_i and times out after TRAIN_TICKS ticks, with the same +2 cycle offset as R5.
- R7: Reset/self-test, calendar programming and link-up have no timeout and wait for completion indefinitely.
- R8: A start or restart command that arrives while busy_o is high is ignored. The phase order and mode_o are unchanged.
- R9: mode_o takes the value of mode_i (bit 0 transmit, bit 1 receive) at the accepted command and holds it, whatever mode_i does, until the next accepted command.
- R10: If start_i and restart_i are high in the same idle cycle, the full start sequence runs.
- R11: done_o, error_o and fail_code_o hold their final values until the next accepted command, which clears them to 0, 0 and 7. done_o and error_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Full bring-up command |
| restart_i | input | 1 | Shortened re-synchronisation command |
| mode_i | input | 2 | Bit 0 transmit enable, bit 1 receive enable |
| timeout_i | input | TMO_W | Timeout in ticks for clock detect and calendar sync |
| phase_go_o | output | 6 | One-hot, one-cycle start pulse per phase |
| phase_done_i | input | 1 | Completion strobe from the active phase handler |
| phase_err_i | input | 1 | Error flag, sampled with phase_done_i |
| mode_o | output | 2 | Mode captured at the accepted command |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Last sequence completed successfully |
| error_o | output | 1 | Last sequence aborted |
| fail_code_o | output | 3 | Index of the failed phase, 7 if none |

## Verification
The hardest situation to reach from the ports is a timeout in a late phase, above all training, whose fixed limit runs to thousands of cycles. A timeout there only happens once every earlier phase has been acknowledged on time. The bench therefore has its handler model acknowledge each phase after a random short delay and then withhold completion for a chosen phase. It counts cycles from that phase's go pulse to the rise of error_o and compares the count with the tick arithmetic. A further directed run pokes start and restart in the middle of a sequence, while mode_i changes, to show that the run in progress is left alone.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;

    localparam int NUM_PHASES = 6;
    localparam int MODE_TX_BIT = 0;
    localparam int MODE_RX_BIT = 1;

    typedef enum logic [2:0] {
        PH_RESET   = 3'd0,
        PH_CALSET  = 3'd1,
        PH_CLKDET  = 3'd2,
        PH_TRAIN   = 3'd3,
        PH_CALSYNC = 3'd4,
        PH_LINKUP  = 3'd5,
        PH_NONE    = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       restart;
        logic [1:0] mode;
    } cmd_t;

    function automatic logic phase_is_timed(phase_e p);
        return (p == PH_CLKDET) || (p == PH_TRAIN) || (p == PH_CALSYNC);
    endfunction

    function automatic phase_e phase_next(phase_e p, logic restart);
        phase_e n;
        case (p)
            PH_RESET:   n = restart ? PH_CLKDET : PH_CALSET;
            PH_CALSET:  n = PH_CLKDET;
            PH_CLKDET:  n = PH_TRAIN;
            PH_TRAIN:   n = PH_CALSYNC;
            PH_CALSYNC: n = PH_LINKUP;
            default:    n = PH_NONE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lbu_cmd_latch.sv
module lbu_cmd_latch
    import link_bringup_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [TMO_W-1:0] timeout_i,
    output cmd_t             cmd_o,
    output logic [TMO_W-1:0] tmo_o
);

    cmd_t             cmd_q;
    logic [TMO_W-1:0] tmo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            tmo_q <= '0;
        end else if (accept_i) begin
            // start has priority when both commands arrive together
            cmd_q.restart <= !start_i;
            cmd_q.mode    <= mode_i;
            tmo_q         <= timeout_i;
        end
    end

    assign cmd_o = cmd_q;
    assign tmo_o = tmo_q;

    a_r9_hold_without_accept: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> (cmd_q == $past(cmd_q)) && (tmo_q == $past(tmo_q)))
        else $error("command fields changed without an accepted command");

endmodule

// File: rtl/lbu_tick_timer.sv
module lbu_tick_timer #(
    parameter int CNT_W    = 10,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    generate
        if (TICK_DIV > 1) begin : g_prescale
            assign tick = (pre_q == PRE_LAST);
        end else begin : g_noprescale
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            pre_q <= '0;
            cnt_q <= load_val_i;
        end else if (run_i) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick && (cnt_q != '0))
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    a_r5_count_never_rises: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> cnt_q <= $past(cnt_q))
        else $error("timeout counter rose without a reload");

    a_r5_expiry_sticks: assert property (@(posedge clk) disable iff (rst)
        (expired_o && !load_i) |=> expired_o)
        else $error("expiry cleared without a reload");

endmodule

// File: rtl/lbu_phase_fsm.sv
module lbu_phase_fsm
    import link_bringup_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept_i,
    input  logic                  restart_i,
    input  logic                  phase_done_i,
    input  logic                  phase_err_i,
    input  logic                  expired_i,
    output logic [NUM_PHASES-1:0] go_o,
    output logic                  tmr_load_o,
    output logic                  tmr_run_o,
    output logic                  train_sel_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  error_o,
    output logic [2:0]            fail_code_o
);

    seq_state_e st_q;
    phase_e     phase_q;
    phase_e     fail_q;
    logic       done_q;
    logic       err_q;
    logic       timed;

    assign timed = phase_is_timed(phase_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            phase_q <= PH_RESET;
            fail_q  <= PH_NONE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (accept_i) begin
                        st_q    <= SQ_ISSUE;
                        phase_q <= PH_RESET;
                        fail_q  <= PH_NONE;
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                    end
                end
                SQ_ISSUE: st_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (phase_done_i) begin
                        if (phase_err_i) begin
                            err_q  <= 1'b1;
                            fail_q <= phase_q;
                            st_q   <= SQ_IDLE;
                        end else if (phase_q == PH_LINKUP) begin
                            done_q <= 1'b1;
                            st_q   <= SQ_IDLE;
                        end else begin
                            phase_q <= phase_next(phase_q, restart_i);
                            st_q    <= SQ_ISSUE;
                        end
                    end else if (timed && expired_i) begin
                        err_q  <= 1'b1;
                        fail_q <= phase_q;
                        st_q   <= SQ_IDLE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NUM_PHASES; g++) begin : g_go
            assign go_o[g] = (st_q == SQ_ISSUE) && (phase_q == phase_e'(g));
        end
    endgenerate

    assign tmr_load_o  = (st_q == SQ_ISSUE) && timed;
    assign tmr_run_o   = (st_q == SQ_WAIT);
    assign train_sel_o = (phase_q == PH_TRAIN);
    assign busy_o      = (st_q != SQ_IDLE);
    assign done_o      = done_q;
    assign error_o     = err_q;
    assign fail_code_o = fail_q;

    a_r2_single_go: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go_o))
        else $error("more than one phase started at once");

    a_r2_forward_only: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_ISSUE && $past(st_q) == SQ_WAIT) |-> phase_q > $past(phase_q))
        else $error("phase order went backwards");

    a_r3_restart_skips_calendar: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_ISSUE && restart_i) |-> phase_q != PH_CALSET)
        else $error("calendar programming started on a restart");

    a_r4_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> (st_q == SQ_IDLE) && (go_o == '0))
        else $error("sequence continued after an error");

    a_r5_timeout_reports: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_WAIT && timed && expired_i && !phase_done_i)
        |=> err_q && (fail_q == $past(phase_q)))
        else $error("timeout not reported against the timed phase");

    a_r11_done_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q))
        else $error("done and error both high");

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import link_bringup_pkg::*;
#(
    parameter int TMO_W       = 8,
    parameter int TICK_DIV    = 4,
    parameter int TRAIN_TICKS = 600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             restart_i,
    input  logic [1:0]       mode_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic [5:0]       phase_go_o,
    input  logic             phase_done_i,
    input  logic             phase_err_i,
    output logic [1:0]       mode_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o,
    output logic [2:0]       fail_code_o
);

    localparam int TRN_W = $clog2(TRAIN_TICKS + 1);
    localparam int CNT_W = (TRN_W > TMO_W) ? TRN_W : TMO_W;

    cmd_t             cmd;
    logic [TMO_W-1:0] tmo_q;
    logic             accept;
    logic             busy;
    logic             tmr_load;
    logic             tmr_run;
    logic             train_sel;
    logic             expired;
    logic [CNT_W-1:0] load_val;

    assign accept = !busy && (start_i || restart_i);

    lbu_cmd_latch #(.TMO_W(TMO_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .timeout_i (timeout_i),
        .cmd_o     (cmd),
        .tmo_o     (tmo_q)
    );

    assign load_val = train_sel ? CNT_W'(TRAIN_TICKS) : CNT_W'(tmo_q);

    lbu_tick_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (load_val),
        .run_i      (tmr_run),
        .expired_o  (expired)
    );

    lbu_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .accept_i     (accept),
        .restart_i    (cmd.restart),
        .phase_done_i (phase_done_i),
        .phase_err_i  (phase_err_i),
        .expired_i    (expired),
        .go_o         (phase_go_o),
        .tmr_load_o   (tmr_load),
        .tmr_run_o    (tmr_run),
        .train_sel_o  (train_sel),
        .busy_o       (busy),
        .done_o       (done_o),
        .error_o      (error_o),
        .fail_code_o  (fail_code_o)
    );

    assign busy_o = busy;
    assign mode_o = cmd.mode;

    a_r9_mode_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_o))
        else $error("mode changed during a sequence");

    a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && (start_i || restart_i)) |=> $stable(mode_o))
        else $error("command accepted while busy");

endmodule

// File: tb/link_bringup_seq_tb.sv
module link_bringup_seq_tb;

    localparam int TMO_W = 8;
    localparam int DIV   = 4;
    localparam int TRAIN = 600;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             restart_i = 1'b0;
    logic [1:0]       mode_i = 2'b00;
    logic [TMO_W-1:0] timeout_i = '0;
    logic [5:0]       phase_go_o;
    logic             phase_done_i = 1'b0;
    logic             phase_err_i = 1'b0;
    logic [1:0]       mode_o;
    logic             busy_o, done_o, error_o;
    logic [2:0]       fail_code_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    link_bringup_seq #(.TMO_W(TMO_W), .TICK_DIV(DIV), .TRAIN_TICKS(TRAIN)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .restart_i(restart_i),
        .mode_i(mode_i), .timeout_i(timeout_i), .phase_go_o(phase_go_o),
        .phase_done_i(phase_done_i), .phase_err_i(phase_err_i), .mode_o(mode_o),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .fail_code_o(fail_code_o)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R2 actual=%0d expected=<150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int onehot_idx(input logic [5:0] v);
        int idx = -1;
        int n = 0;
        for (int i = 0; i < 6; i++) begin
            if (v[i]) begin
                idx = i;
                n++;
            end
        end
        return (n > 1) ? -2 : idx;
    endfunction

    function automatic int exp_phase(input bit rs, input int k);
        if (!rs) return k;
        return (k == 0) ? 0 : k + 1;
    endfunction

    function automatic int exp_timeout_cycles(input int ph, input int tmo);
        int ticks = (ph == 3) ? TRAIN : tmo;
        return ticks * DIV + 2;
    endfunction

    // cmd: 0 start, 1 restart, 2 both together
    task automatic run_seq(input int cmd, input logic [1:0] md, input int tmo,
                           input int err_at, input int hang_at,
                           input bit poke_busy, input bit hold_long);
        bit rs = (cmd == 1);
        int len = rs ? 5 : 6;
        @(negedge clk);
        start_i   = (cmd != 1);
        restart_i = (cmd != 0);
        mode_i    = md;
        timeout_i = TMO_W'(tmo);
        @(negedge clk);
        start_i = 1'b0;
        restart_i = 1'b0;
        mode_i = ~md;
        timeout_i = '1;
        chk(busy_o && !done_o && !error_o && fail_code_o == 3'd7, "R11 cleared on accept",
            {busy_o, done_o, error_o, fail_code_o}, 32'b100111);
        for (int k = 0; k < len; k++) begin
            int w = 0;
            int idx;
            int ex = exp_phase(rs, k);
            while (phase_go_o == '0 && w < 5000) begin
                @(negedge clk);
                w++;
            end
            idx = onehot_idx(phase_go_o);
            chk(idx == ex, rs ? "R3 restart order" : (cmd == 2 ? "R10 both cmds" : "R2 start order"), idx, ex);
            chk(mode_o == md, "R9 mode latched", mode_o, md);
            if (idx == hang_at) begin
                int c = 0;
                int exc = exp_timeout_cycles(idx, tmo);
                while (!error_o && c < 5000) begin
                    @(negedge clk);
                    c++;
                end
                chk(c == exc, (idx == 3) ? "R6 training timeout" : "R5 timeout", c, exc);
                chk(fail_code_o == 3'(idx) && !busy_o, "R5 timeout code", fail_code_o, idx);
                return;
            end
            if (hold_long && idx == 0) begin
                repeat (3000) @(negedge clk);
                chk(busy_o && !error_o, "R7 untimed wait", {busy_o, error_o}, 2);
            end
            begin
                int d = 1 + int'($urandom % 4);
                for (int j = 0; j < d; j++) begin
                    @(negedge clk);
                    if (poke_busy && k == 2 && j == 0) begin
                        start_i = 1'b1;
                        restart_i = 1'b1;
                        mode_i = ~md;
                    end else begin
                        start_i = 1'b0;
                        restart_i = 1'b0;
                    end
                end
                start_i = 1'b0;
                restart_i = 1'b0;
            end
            phase_done_i = 1'b1;
            phase_err_i  = (idx == err_at);
            @(negedge clk);
            phase_done_i = 1'b0;
            phase_err_i  = 1'b0;
            if (poke_busy && k == 2)
                chk(mode_o == md && busy_o, "R8 busy command ignored", mode_o, md);
            if (idx == err_at) begin
                chk(error_o && !busy_o && !done_o, "R4 abort", {error_o, busy_o, done_o}, 4);
                chk(fail_code_o == 3'(idx), "R4 fail code", fail_code_o, idx);
                begin
                    int seen = 0;
                    repeat (12) begin
                        @(negedge clk);
                        if (phase_go_o != '0) seen++;
                    end
                    chk(seen == 0, "R4 no later phase", seen, 0);
                end
                chk(error_o && fail_code_o == 3'(idx), "R11 error sticky", fail_code_o, idx);
                return;
            end
        end
        chk(done_o && !busy_o && !error_o && fail_code_o == 3'd7, "R2 completion",
            {done_o, busy_o, error_o, fail_code_o}, 32'b100111);
        repeat (5) @(negedge clk);
        chk(done_o && mode_o == md, "R11 done sticky", {done_o, mode_o}, {1'b1, md});
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !error_o && fail_code_o == 3'd7 && phase_go_o == '0,
            "R1 reset state", {busy_o, done_o, error_o, fail_code_o}, 7);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy_o && fail_code_o == 3'd7, "R1 idle after reset", busy_o, 0);

        run_seq(0, 2'b11, 10, -1, -1, 0, 0);
        run_seq(1, 2'b01, 10, -1, -1, 0, 0);
        run_seq(2, 2'b10, 10, -1, -1, 0, 0);
        run_seq(0, 2'b11, 10, -1, -1, 1, 0);
        run_seq(0, 2'b10, 10, -1, -1, 0, 1);
        run_seq(0, 2'b11, 5, -1, 2, 0, 0);
        run_seq(1, 2'b11, 7, -1, 4, 0, 0);
        run_seq(1, 2'b01, 3, -1, 3, 0, 0);
        run_seq(0, 2'b11, 0, -1, 2, 0, 0);
        run_seq(0, 2'b11, 10, 1, -1, 0, 0);
        run_seq(1, 2'b10, 10, 5, -1, 0, 0);
        run_seq(0, 2'b01, 10, 0, -1, 0, 0);

        for (int it = 0; it < 24; it++) begin
            int c  = int'($urandom % 3);
            int t  = 2 + int'($urandom % 19);
            int e  = int'($urandom % 8);
            int h  = -1;
            logic [1:0] m = 2'($urandom % 4);
            if (($urandom % 4) == 0) begin
                h = ($urandom % 2) ? 2 : 4;
                e = -1;
            end
            run_seq(c, m, t, (e >= 6) ? -1 : e, h, 0, 0);
        end

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule